// File: doc/BRIEF.md
# Bouncing One-Hot Pattern Generator

This block drives a 4-bit one-hot pattern whose single lit bit sweeps from the top position down to the bottom position, then climbs back up, and repeats for as long as stepping continues. A 4-bit code such as 0010 is reached once while falling and once while rising, so the output alone cannot say where the sweep goes next. For that reason the block does not keep its sequencing state in the output width. It keeps a wider ring register that holds exactly one set bit and rotates right by one position on each enabled clock. Each output bit is a fixed OR of two mirrored ring taps. The fold of the ring produces the bounce, and no direction flag is kept.

Two sweep modes are offered. In plain mode a 6-position ring gives a 6-step bounce. In dwell mode an 8-position ring is used, and both end codes last for two consecutive steps. The mode is captured only while reset is held, so the ring can never be left with a width that does not match its contents. The raw ring state is also brought out so that a neighbour or a bench can see the exact phase.

Top module: `bounce_onehot_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the ring is loaded with its seed: `ring_o` = 8'b0010_0000 in plain mode (`dwell_mode`=0) or 8'b1000_0000 in dwell mode (`dwell_mode`=1), and `pattern_o` reads 4'b1000 (bit 3 lit).
- R2: Reset takes priority over `step_en`. A reset edge with `step_en` high still leaves the seed value.
- R3: In plain mode, enabled steps after reset produce `pattern_o` = 1000, 0100, 0010, 0001, 0010, 0100, and the sequence then repeats from 1000.
- R4: In plain mode the ring rotates right inside bits [5:0]: bit 0 moves to bit 5, and `ring_o[7:6]` stay 0.
- R5: In dwell mode, enabled steps produce `pattern_o` = 1000, 0100, 0010, 0001, 0001, 0010, 0100, 1000, and the sequence then repeats. `ring_o` rotates right across all 8 bits, with bit 0 moving to bit 7.
- R6: At a rising edge where `rst` and `step_en` are both low, both `ring_o` and `pattern_o` keep their values.
- R7: `dwell_mode` is sampled only at reset edges. A change of this input outside reset has no effect on the sequence until the next reset.
- R8: After reset, exactly one bit of `pattern_o` and exactly one bit of `ring_o` are high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; also captures the mode |
| step_en | input | 1 | Advances the ring by one position on this edge |
| dwell_mode | input | 1 | 0 = plain bounce, 1 = doubled dwell at both ends; sampled at reset |
| pattern_o | output | 4 | One-hot sweep pattern, folded from the ring |
| ring_o | output | 8 | Raw single-one ring state |

## Verification
Two functions of this block can fall in the same cycle: reset and the step enable, and the capture of the mode and the stepping. The bench holds `step_en` high across a reset edge and expects the seed rather than an advanced ring. It also toggles `dwell_mode` in the middle of a plain-mode run while steps continue, and expects the plain sequence and ring width to go on unchanged until a later reset with the new mode level starts the dwell sequence from its own seed.

// File: rtl/bounce_pkg.sv
package bounce_pkg;

  // Sweep variant selected at reset.
  typedef enum logic {
    SWEEP_PLAIN = 1'b0,
    SWEEP_DWELL = 1'b1
  } sweep_mode_e;

  // Default output width; ring widths derive from it.
  localparam int unsigned PAT_W_DEF = 4;

  // Ring positions for the plain bounce: top and bottom visited once.
  function automatic int unsigned plain_ring_len(input int unsigned pat_w);
    return 2 * pat_w - 2;
  endfunction

  // Ring positions for the dwell bounce: every code visited twice.
  function automatic int unsigned dwell_ring_len(input int unsigned pat_w);
    return 2 * pat_w;
  endfunction

endpackage

// File: rtl/mode_capture.sv
module mode_capture
  import bounce_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  sweep_mode_e mode_in,
  output sweep_mode_e mode_q
);

  // Mode register follows the input only on reset edges.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_in;
  end

  // The captured mode never moves unless the previous edge was a reset edge.
  assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));

endmodule

// File: rtl/ring_rotor.sv
module ring_rotor
  import bounce_pkg::*;
#(
  parameter int unsigned RING_W  = 8,
  parameter int unsigned PLAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  sweep_mode_e       seed_mode,
  input  sweep_mode_e       run_mode,
  output logic [RING_W-1:0] ring_q,
  output logic              wrap_evt
);

  localparam int unsigned PAD_W = RING_W - PLAIN_W;
  localparam logic [RING_W-1:0] SEED_DWELL = {1'b1, {(RING_W-1){1'b0}}};
  localparam logic [RING_W-1:0] SEED_PLAIN =
    {{PAD_W{1'b0}}, 1'b1, {(PLAIN_W-1){1'b0}}};

  logic [RING_W-1:0] ring_nxt;

  // Right rotation that closes at the top of the active ring.
  always_comb begin
    ring_nxt = '0;
    if (run_mode == SWEEP_DWELL) begin
      ring_nxt = {ring_q[0], ring_q[RING_W-1:1]};
    end else begin
      ring_nxt[PLAIN_W-1:0] = {ring_q[0], ring_q[PLAIN_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= (seed_mode == SWEEP_DWELL) ? SEED_DWELL : SEED_PLAIN;
    end else if (step_en) begin
      ring_q <= ring_nxt;
    end
  end

  // Named event: the single one leaves bit 0 on this step.
  assign wrap_evt = step_en & ring_q[0] & ~rst;

  assert_seed_dwell_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && ($past(seed_mode) == SWEEP_DWELL) |-> ring_q[RING_W-1]);

  assert_seed_plain_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && ($past(seed_mode) == SWEEP_PLAIN) |-> ring_q[PLAIN_W-1]);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(ring_q));

  assert_single_one_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(ring_q) == 1);

  assert_plain_pad_R4: assert property (@(posedge clk) disable iff (rst)
    (run_mode == SWEEP_PLAIN) |-> (ring_q[RING_W-1:PLAIN_W] == '0));

  assert_wrap_top_R4: assert property (@(posedge clk) disable iff (rst)
    wrap_evt && (run_mode == SWEEP_PLAIN) |=> ring_q[PLAIN_W-1]);

endmodule

// File: rtl/tap_folder.sv
module tap_folder
  import bounce_pkg::*;
#(
  parameter int unsigned PAT_W  = 4,
  parameter int unsigned RING_W = 8
) (
  input  sweep_mode_e       mode,
  input  logic [RING_W-1:0] ring,
  output logic [PAT_W-1:0]  pat
);

  logic [PAT_W-1:0] plain_fold;
  logic [PAT_W-1:0] dwell_fold;

  // Output bit k is the OR of the two ring taps that mirror about the fold.
  for (genvar k = 0; k < PAT_W; k++) begin : g_fold
    if ((k == 0) || (k == PAT_W - 1)) begin : g_end
      assign plain_fold[k] = ring[k + PAT_W - 2];
    end else begin : g_mid
      assign plain_fold[k] = ring[k + PAT_W - 2] | ring[PAT_W - 2 - k];
    end
    assign dwell_fold[k] = ring[k + PAT_W] | ring[PAT_W - 1 - k];
  end

  assign pat = (mode == SWEEP_DWELL) ? dwell_fold : plain_fold;

endmodule

// File: rtl/bounce_onehot_gen.sv
module bounce_onehot_gen
  import bounce_pkg::*;
#(
  parameter int unsigned PAT_W = PAT_W_DEF
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          step_en,
  input  logic                          dwell_mode,
  output logic [PAT_W-1:0]              pattern_o,
  output logic [dwell_ring_len(PAT_W)-1:0] ring_o
);

  localparam int unsigned RING_W  = dwell_ring_len(PAT_W);
  localparam int unsigned PLAIN_W = plain_ring_len(PAT_W);
  localparam logic [PAT_W-1:0] CODE_TOP = {1'b1, {(PAT_W-1){1'b0}}};
  localparam logic [PAT_W-1:0] CODE_NXT = CODE_TOP >> 1;
  localparam logic [PAT_W-1:0] CODE_BOT = {{(PAT_W-1){1'b0}}, 1'b1};

  sweep_mode_e mode_req;
  sweep_mode_e mode_live;
  logic        wrap_evt;

  assign mode_req = dwell_mode ? SWEEP_DWELL : SWEEP_PLAIN;

  mode_capture u_mode (
    .clk     (clk),
    .rst     (rst),
    .mode_in (mode_req),
    .mode_q  (mode_live)
  );

  ring_rotor #(
    .RING_W  (RING_W),
    .PLAIN_W (PLAIN_W)
  ) u_ring (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .seed_mode (mode_req),
    .run_mode  (mode_live),
    .ring_q    (ring_o),
    .wrap_evt  (wrap_evt)
  );

  tap_folder #(
    .PAT_W  (PAT_W),
    .RING_W (RING_W)
  ) u_fold (
    .mode (mode_live),
    .ring (ring_o),
    .pat  (pattern_o)
  );

  assert_pattern_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(pattern_o) == 1);

  assert_plain_descend_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_live == SWEEP_PLAIN) && step_en && (pattern_o == CODE_TOP)
    |=> pattern_o == CODE_NXT);

  assert_dwell_linger_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_live == SWEEP_DWELL) && step_en && ring_o[PAT_W]
    |=> pattern_o == CODE_BOT);

  assert_wrap_top_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_live == SWEEP_DWELL) && wrap_evt |=> pattern_o == CODE_TOP);

  assert_pattern_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(pattern_o));

endmodule

// File: tb/tb_bounce_onehot_gen.sv
module tb_bounce_onehot_gen;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic       dwell_mode = 1'b0;
  logic [3:0] pattern_o;
  logic [7:0] ring_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bounce_onehot_gen dut (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .dwell_mode (dwell_mode),
    .pattern_o  (pattern_o),
    .ring_o     (ring_o)
  );

  // Expected pattern at phase p of the sweep, restated from R3 and R5.
  function automatic logic [3:0] exp_pat(input bit dwell, input int p);
    int idx;
    if (dwell) idx = (p <= 3) ? 3 - p : p - 4;
    else       idx = (p <= 3) ? 3 - p : p - 3;
    return 4'(1 << idx);
  endfunction

  // Expected ring at phase p: one bit walking down from the seed.
  function automatic logic [7:0] exp_ring(input bit dwell, input int p);
    return dwell ? 8'(8'h80 >> p) : 8'(8'h20 >> p);
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk4(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Inputs change at a falling edge; results are read at the next falling edge.
  task automatic tick(input bit r, input bit en);
    @(negedge clk);
    rst = r;
    step_en = en;
    @(negedge clk);
    rst = 1'b0;
    step_en = 1'b0;
  endtask

  task automatic do_reset(input bit dwell, input bit en);
    @(negedge clk);
    dwell_mode = dwell;
    tick(1'b1, en);
  endtask

  // Steps through revs revolutions, checking each phase (R3/R4 or R5, R8).
  task automatic run_sweep(input bit dwell, input int revs, input int start);
    int len = dwell ? 8 : 6;
    for (int s = 1; s <= revs * len; s++) begin
      int p = (start + s) % len;
      tick(1'b0, 1'b1);
      if (dwell) begin
        chk4("R5 dwell pattern", pattern_o, exp_pat(1'b1, p));
        chk8("R5 dwell ring", ring_o, exp_ring(1'b1, p));
      end else begin
        chk4("R3 plain pattern", pattern_o, exp_pat(1'b0, p));
        chk8("R4 plain ring", ring_o, exp_ring(1'b0, p));
      end
      checks++;
      if ($countones(pattern_o) != 1) begin
        failures++;
        $display("FAIL R8 onehot actual=%b expected=one bit set", pattern_o);
      end
    end
  endtask

  task automatic t_reset_seed();
    do_reset(1'b0, 1'b0);
    chk8("R1 plain seed ring", ring_o, 8'b0010_0000);
    chk4("R1 plain seed pattern", pattern_o, 4'b1000);
    do_reset(1'b1, 1'b0);
    chk8("R1 dwell seed ring", ring_o, 8'b1000_0000);
    chk4("R1 dwell seed pattern", pattern_o, 4'b1000);
  endtask

  task automatic t_reset_beats_step();
    do_reset(1'b0, 1'b0);
    run_sweep(1'b0, 0, 0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    do_reset(1'b0, 1'b1);
    chk8("R2 reset over enable ring", ring_o, 8'b0010_0000);
    chk4("R2 reset over enable pattern", pattern_o, 4'b1000);
    do_reset(1'b1, 1'b1);
    chk8("R2 reset over enable dwell ring", ring_o, 8'b1000_0000);
  endtask

  task automatic t_plain_sweep();
    do_reset(1'b0, 1'b0);
    run_sweep(1'b0, 3, 0);
  endtask

  task automatic t_dwell_sweep();
    do_reset(1'b1, 1'b0);
    run_sweep(1'b1, 3, 0);
  endtask

  task automatic t_hold();
    do_reset(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      tick(1'b0, 1'b0);
      chk8("R6 hold ring", ring_o, exp_ring(1'b1, 3));
      chk4("R6 hold pattern", pattern_o, exp_pat(1'b1, 3));
    end
    run_sweep(1'b1, 1, 3);
  endtask

  task automatic t_mode_change();
    do_reset(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    @(negedge clk);
    dwell_mode = 1'b1;
    run_sweep(1'b0, 2, 2);
    do_reset(1'b1, 1'b0);
    chk8("R7 new mode after reset", ring_o, 8'b1000_0000);
    run_sweep(1'b1, 1, 0);
    @(negedge clk);
    dwell_mode = 1'b0;
    run_sweep(1'b1, 1, 0);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_seed();
    t_reset_beats_step();
    t_plain_sweep();
    t_dwell_sweep();
    t_hold();
    t_mode_change();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule